// File: doc/BRIEF.md
# Per-Channel Soft Mute Gain Ramp

This block sits in an audio interpolation path at the four-times-oversampled point and scales the left and right samples by two independent gains. Each channel has its own mute request. Raising a request walks that channel's gain down from unity to silence. Lowering it walks the gain back up. The gain moves one step per input-rate tick, so a full ramp takes 512 input sample periods. That is roughly 11.6 ms at 44.1 kHz.

Samples keep arriving with a strobe whether a channel is muted, ramping or open. Each sample is multiplied by the gain the channel holds at that strobe, and the product is registered to the output. The active-low reset is a hard override. While it is low, both outputs read zero at once, with no ramp. When it is released, both gains are back at unity immediately.

Top module: `soft_mute_gain`

## Requirements
- R1: While rst_n is low, out_l, out_r and out_vld are zero immediately, whatever the mute requests are. After release, both gains are unity, so the first sample passes through unchanged even if a mute request is high.
- R2: A channel's gain changes only in a cycle where fs_tick is high, and by at most one step.
- R3: With a channel's mute request high, each fs_tick lowers its gain by one until it reaches 0. A sample taken at gain 0 gives exactly 0.
- R4: With a channel's mute request low, each fs_tick raises its gain by one until it reaches 512. A sample taken at gain 512 appears unchanged.
- R5: If a request changes mid-ramp, the ramp reverses from the gain reached so far. There is no jump.
- R6: The two channels are fully independent. One channel's request never alters the other channel's gain or output.
- R7: The output is sample × gain / 512, rounded toward zero (a truncated magnitude). Samples are 25-bit two's complement and gain is an unsigned value from 0 to 512.
- R8: out_vld is high exactly one cycle after a cycle with smp_vld high. The outputs change only on a strobe and hold their value otherwise.
- R9: A sample is scaled by the gain held before any fs_tick in the same cycle takes effect.
- R10: The gain never leaves the range 0 to 512.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, hard mute |
| fs_tick | input | 1 | One pulse per input sample period, advances the ramps |
| mute_l | input | 1 | Left mute request, high = ramp to silence |
| mute_r | input | 1 | Right mute request, high = ramp to silence |
| smp_vld | input | 1 | Sample strobe |
| smp_l | input | 25 | Left sample, signed |
| smp_r | input | 25 | Right sample, signed |
| out_vld | output | 1 | Output strobe, one cycle after smp_vld |
| out_l | output | 25 | Scaled left sample, signed |
| out_r | output | 25 | Scaled right sample, signed |

## Verification
The bound checker tests these rules on every clock:
- the gain stays within its bounds;
- the gain steps only on a tick, by one, in the direction the request sets;
- the output holds between strobes, and out_vld follows the strobe;
- gain 0 gives zero output and gain 512 gives the input unchanged;
- the outputs are zero during reset.

Some behaviour needs the bench's sequences to show. These are the exact rounding toward zero at intermediate gains, reversal from the current value, independence of one channel while the other ramps, gain taken before a coincident tick, and unity restored at once after reset. The bench checks these against its own gain model and rounding function.

// File: rtl/smute_pkg.sv
package smute_pkg;
  parameter int SMUTE_DW = 25;  // sample width
  parameter int SMUTE_SH = 9;   // log2 of unity gain
  parameter int SMUTE_NCH = 2;  // channel count
endpackage

// File: rtl/smute_gain_ramp.sv
module smute_gain_ramp #(
  parameter int SH = 9,
  parameter int GW = SH + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          mute_req,
  output logic [GW-1:0] gain
);
  localparam logic [GW-1:0] UNITY = GW'(1) << SH;

  logic [GW-1:0] gain_q;
  logic [GW-1:0] gain_d;

  // next-state: one step toward the target, only on the rate tick
  always_comb begin
    gain_d = gain_q;
    if (step_en) begin
      if (mute_req) begin
        if (gain_q != '0) gain_d = gain_q - GW'(1);
      end else begin
        if (gain_q < UNITY) gain_d = gain_q + GW'(1);
      end
    end
  end

  // reset returns unity so release needs no ramp
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gain_q <= UNITY;
    else        gain_q <= gain_d;
  end

  assign gain = gain_q;
endmodule

// File: rtl/smute_scaler.sv
module smute_scaler #(
  parameter int DW = 25,
  parameter int SH = 9,
  parameter int GW = SH + 1
) (
  input  logic signed [DW-1:0] smp,
  input  logic        [GW-1:0] gain,
  output logic signed [DW-1:0] res
);
  localparam int PW = DW + GW + 1;

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] biased;

  always_comb begin
    prod   = PW'(smp) * $signed({1'b0, gain});
    // negative products get 2^SH-1 added so the shift truncates toward zero
    biased = prod + $signed({{(PW-SH){1'b0}}, {SH{prod[PW-1]}}});
    res    = DW'(biased >>> SH);
  end
endmodule

// File: rtl/soft_mute_gain.sv
module soft_mute_gain #(
  parameter int DW = smute_pkg::SMUTE_DW,
  parameter int SH = smute_pkg::SMUTE_SH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fs_tick,
  input  logic                 mute_l,
  input  logic                 mute_r,
  input  logic                 smp_vld,
  input  logic signed [DW-1:0] smp_l,
  input  logic signed [DW-1:0] smp_r,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_l,
  output logic signed [DW-1:0] out_r
);
  localparam int NCH = smute_pkg::SMUTE_NCH;
  localparam int GW  = SH + 1;

  logic        [NCH-1:0]         mute_v;
  logic signed [NCH-1:0][DW-1:0] smp_v;
  logic        [NCH-1:0][GW-1:0] gain_v;
  logic signed [NCH-1:0][DW-1:0] scl_v;
  logic signed [NCH-1:0][DW-1:0] out_q;
  logic signed [NCH-1:0][DW-1:0] out_d;
  logic                          vld_q;

  assign mute_v = {mute_r, mute_l};
  assign smp_v  = {smp_r, smp_l};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    smute_gain_ramp #(.SH(SH), .GW(GW)) ramp_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_en  (fs_tick),
      .mute_req (mute_v[c]),
      .gain     (gain_v[c])
    );

    smute_scaler #(.DW(DW), .SH(SH), .GW(GW)) scl_i (
      .smp  (smp_v[c]),
      .gain (gain_v[c]),
      .res  (scl_v[c])
    );

    // next-state: capture the scaled sample only on a strobe
    always_comb begin
      out_d[c] = out_q[c];
      if (smp_vld) out_d[c] = scl_v[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q[c] <= '0;
      else        out_q[c] <= out_d[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= smp_vld;
  end

  assign out_vld = vld_q;
  assign out_l   = out_q[0];
  assign out_r   = out_q[1];
endmodule

// File: rtl/smute_chk.sv
module smute_chk #(
  parameter int DW = 25,
  parameter int SH = 9,
  parameter int GW = SH + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fs_tick,
  input logic                 mute_l,
  input logic                 smp_vld,
  input logic signed [DW-1:0] smp_l,
  input logic                 out_vld,
  input logic signed [DW-1:0] out_l,
  input logic signed [DW-1:0] out_r,
  input logic        [GW-1:0] gain_l
);
  localparam logic [GW-1:0] UNITY = GW'(1) << SH;

  p_gain_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gain_l <= UNITY);

  p_gain_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_tick |=> $stable(gain_l));

  p_gain_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_tick && mute_l && gain_l != '0) |=> gain_l == $past(gain_l) - GW'(1));

  p_gain_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_tick && !mute_l && gain_l < UNITY) |=> gain_l == $past(gain_l) + GW'(1));

  p_zero_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && gain_l == '0) |=> out_l == '0);

  p_unity_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && gain_l == UNITY) |=> out_l == $past(smp_l));

  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(out_l));

  p_vld_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> out_vld);

  p_vld_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> !out_vld);

  // reset override: held low across two edges means outputs are cleared
  p_reset_zero_r1: assert property (@(posedge clk)
    (!rst_n && $past(!rst_n)) |-> (out_l == '0 && out_r == '0 && !out_vld));
endmodule

bind soft_mute_gain smute_chk #(.DW(DW), .SH(SH), .GW(GW)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .fs_tick (fs_tick),
  .mute_l  (mute_l),
  .smp_vld (smp_vld),
  .smp_l   (smp_l),
  .out_vld (out_vld),
  .out_l   (out_l),
  .out_r   (out_r),
  .gain_l  (gain_v[0])
);

// File: tb/soft_mute_gain_tb.sv
module soft_mute_gain_tb_top;
  localparam int DW = 25;
  localparam int UNITY = 512;

  logic clk = 1'b0;
  logic rst_n;
  logic fs_tick, mute_l, mute_r, smp_vld;
  logic signed [DW-1:0] smp_l, smp_r;
  logic out_vld;
  logic signed [DW-1:0] out_l, out_r;

  int n_chk = 0;
  int n_bad = 0;
  int gl = UNITY;
  int gr = UNITY;
  logic signed [DW-1:0] hold_l = '0;
  logic signed [DW-1:0] hold_r = '0;
  bit done = 0;

  always #10 clk = ~clk;

  soft_mute_gain dut_i (
    .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .mute_l(mute_l), .mute_r(mute_r),
    .smp_vld(smp_vld), .smp_l(smp_l), .smp_r(smp_r),
    .out_vld(out_vld), .out_l(out_l), .out_r(out_r)
  );

  function automatic logic signed [DW-1:0] exp_scale(logic signed [DW-1:0] s, int g);
    longint p = longint'(s) * longint'(g);
    longint q;
    if (p < 0) q = -((-p) / 512);
    else       q = p / 512;
    return DW'(q);
  endfunction

  function automatic int ramp(int g, logic m);
    if (m) return (g > 0) ? g - 1 : 0;
    return (g < UNITY) ? g + 1 : UNITY;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one cycle, then compare after the edge
  task automatic step(logic v, logic tk, logic ml, logic mr,
                      logic signed [DW-1:0] sl, logic signed [DW-1:0] sr, string tag);
    logic signed [DW-1:0] el, er;
    smp_vld = v; fs_tick = tk; mute_l = ml; mute_r = mr; smp_l = sl; smp_r = sr;
    el = v ? exp_scale(sl, gl) : hold_l;
    er = v ? exp_scale(sr, gr) : hold_r;
    @(posedge clk);
    #2;
    if (tk) begin
      gl = ramp(gl, ml);
      gr = ramp(gr, mr);
    end
    hold_l = el;
    hold_r = er;
    chk(out_l == el, tag, out_l, el);
    chk(out_r == er, tag, out_r, er);
    chk(out_vld == v, v ? tag : "R8", out_vld, v);
  endtask

  function automatic string gtag(int g);
    if (g == 0) return "R3";
    if (g == UNITY) return "R4";
    return "R7";
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    int seed;
    logic signed [DW-1:0] a;
    rst_n = 1'b0; fs_tick = 0; mute_l = 1; mute_r = 1; smp_vld = 1;
    smp_l = 25'sd1000; smp_r = -25'sd1000;
    seed = $urandom(32'h1234_5678);
    repeat (3) @(posedge clk);
    #2;
    // R1: outputs zero in reset even with strobes and mutes
    chk(out_l == 0 && out_r == 0 && !out_vld, "R1", out_l, 0);
    #5 rst_n = 1'b1;
    // R1: unity right after release although muted
    step(1, 0, 1, 1, 25'sd12345, -25'sd777, "R1");

    // R3 + R6: left ramps down, right open passes unchanged
    for (int i = 0; i < 520; i++) begin
      a = DW'($signed($urandom));
      step(1, 1, 1, 0, a, a, (i % 2) ? "R6" : gtag(gl));
    end
    step(1, 0, 1, 0, 25'sd16777215, -25'sd16777216, "R3");
    chk(out_l == 0, "R3", out_l, 0);

    // R4: ramp back up
    for (int i = 0; i < 530; i++) begin
      a = DW'($signed($urandom));
      step(1, 1, 0, 0, a, -a, gtag(gl));
    end

    // R5: reverse mid-ramp (right channel)
    for (int i = 0; i < 100; i++) step(1, 1, 0, 1, 25'sd300000, -25'sd300001, "R5");
    for (int i = 0; i < 40; i++)  step(1, 1, 0, 0, -25'sd99999, 25'sd4097, "R5");

    // R9: strobe with coincident tick uses gain before the tick
    step(1, 1, 0, 1, 25'sd511, 25'sd1000001, "R9");
    step(1, 1, 0, 1, -25'sd513, -25'sd1000001, "R9");

    // R8 + R2: no strobes, outputs hold, no tick leaves gain
    for (int i = 0; i < 10; i++) step(0, 0, 1, 1, 25'sd5, 25'sd5, "R8");
    step(1, 0, 0, 0, 25'sd1024, -25'sd1024, "R2");

    // R7: rounding toward zero at odd magnitudes
    step(1, 0, 0, 1, -25'sd1, -25'sd3, "R7");
    step(1, 0, 0, 1, 25'sd1, 25'sd3, "R7");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic ml, mr;
      ml = ($urandom % 600) == 0 ? ~mute_l : mute_l;
      mr = ($urandom % 700) == 0 ? ~mute_r : mute_r;
      case ($urandom % 8)
        0: a = -25'sd16777216;
        1: a = 25'sd16777215;
        2: a = -25'sd1;
        default: a = DW'($signed($urandom));
      endcase
      step(1'($urandom % 2), 1'($urandom % 2), ml, mr, a, -a, gtag(gl));
    end

    // R1: reset mid-ramp zeroes at once, release restores unity
    for (int i = 0; i < 50; i++) step(1, 1, 1, 1, 25'sd70000, 25'sd70000, "R3");
    rst_n = 1'b0;
    #2;
    chk(out_l == 0 && out_r == 0 && !out_vld, "R1", out_l, 0);
    gl = UNITY; gr = UNITY; hold_l = '0; hold_r = '0;
    repeat (2) @(posedge clk);
    #3 rst_n = 1'b1;
    step(1, 0, 1, 1, 25'sd70000, -25'sd70001, "R1");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule